// File: doc/BRIEF.md
# Three-Wire Synthesizer Register Writer

This block is a write-only serial master for loading control words into a frequency synthesizer over three wires: an active-low enable, a serial clock and a data line. A host presents a 4-bit register address, a data value and a half-period setting, then pulses a start strobe. The block combines address and data into one 22-bit word and shifts it out most significant bit first. After the last bit it releases the link in a fixed order and pulses done.

The receiver captures data on each rising serial-clock edge. For that reason the data line changes only while the serial clock is low. The serial-clock half-period comes from a programmable count of system clocks, captured when a transfer is accepted. A data value too wide for the 18-bit field is refused with a one-cycle error pulse, and the link stays untouched.

Top module: `synth_link_writer`

## Requirements
- R1: After reset, link_en_no and link_clk_o are high, link_dat_o is low, and busy_o, done_o and err_o are low.
- R2: Each transfer produces exactly 22 rising serial-clock edges while enable is low. The word carries the address in bits 3:0 and the 18-bit data value in bits 21:4.
- R3: Word bits are presented from bit 21 down to bit 0, one bit per rising serial-clock edge.
- R4: Enable falls while the serial clock is high. The serial clock never falls while enable is high.
- R5: While enable is low, the data line changes only in the cycle the serial clock falls. It is unchanged at every rising edge and for the whole high phase.
- R6: After the last bit, the serial clock falls first. Then enable rises while the clock is still low, and then the clock rises. The link then idles with enable and clock high.
- R7: Every serial-clock phase lasts H system clocks, where H is max(half_i, 2) captured at the accepted start. A transfer lasts 47·H cycles: one opening phase, 44 bit phases and two release phases.
- R8: A start whose data_i has any bit set above bit 17 sets err_o for exactly one cycle after the start edge. Enable stays high and busy_o stays low.
- R9: A start that arrives while busy_o is high is ignored. The word in flight is unchanged and no second transfer follows.
- R10: busy_o goes high in the cycle after an accepted start. done_o is high for exactly one cycle, the one in which the serial clock returns high after release, and busy_o is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled while idle |
| addr_i | input | 4 | Register address, goes to word bits 3:0 |
| data_i | input | DIN_W | Data value, must fit in 18 bits |
| half_i | input | HALF_W | Serial-clock half-period in system clocks (values below 2 give 2) |
| link_en_no | output | 1 | Link enable, active low |
| link_clk_o | output | 1 | Serial clock, idles high |
| link_dat_o | output | 1 | Serial data |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse when a transfer completes |
| err_o | output | 1 | One-cycle pulse when a start is refused for data range |

## Verification
A wrong phase counter appears as a serial-clock low or high run that differs from H, or as a completion cycle other than 47·H. The next clock edge exposes it. A shift register that is loaded late or shifted wrongly appears as a wrong reconstructed word at the 22nd rising edge. A wrong bit count appears as a rise count other than 22, or as an enable release that occurs with the clock high. A state machine that accepts a second start, or re-enters the opening phase, appears as an extra enable fall within a few phases of the stray strobe.

// File: rtl/synth_link_pkg.sv
package synth_link_pkg;
  localparam int unsigned ADDR_W  = 4;
  localparam int unsigned DATA_W  = 18;
  localparam int unsigned FRAME_W = ADDR_W + DATA_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPEN,
    ST_BIT_LO,
    ST_BIT_HI,
    ST_REL_CLK,
    ST_REL_EN
  } link_state_e;

  function automatic logic [FRAME_W-1:0] pack_word(input logic [ADDR_W-1:0] addr,
                                                   input logic [DATA_W-1:0] data);
    return {data, addr};
  endfunction
endpackage

// File: rtl/link_phase_timer.sv
module link_phase_timer #(
  parameter int unsigned HALF_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [HALF_W-1:0] half_i,
  input  logic              run_i,
  output logic              tick_o
);
  localparam logic [HALF_W-1:0] MIN_HALF = HALF_W'(2);

  logic [HALF_W-1:0] lim_q;
  logic [HALF_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == lim_q - HALF_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_q <= MIN_HALF;
      cnt_q <= '0;
    end else begin
      if (load_i) lim_q <= (half_i < MIN_HALF) ? MIN_HALF : half_i;
      if (!run_i || tick_o) cnt_q <= '0;
      else                  cnt_q <= cnt_q + HALF_W'(1);
    end
  end

  // R7: phase count never passes its limit
  a_r7_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < lim_q);
  // R7: limit never below the floor
  a_r7_lim_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lim_q >= MIN_HALF);
endmodule

// File: rtl/link_word_shifter.sv
module link_word_shifter #(
  parameter int unsigned FRAME_W = 22
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] word_i,
  input  logic               shift_i,
  output logic               msb_o,
  output logic               last_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sr_q;
  logic [CNT_W-1:0]   left_q;

  assign msb_o  = sr_q[FRAME_W-1];
  assign last_o = (left_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      left_q <= '0;
    end else if (load_i) begin
      sr_q   <= word_i;
      left_q <= CNT_W'(FRAME_W);
    end else if (shift_i) begin
      sr_q   <= {sr_q[FRAME_W-2:0], 1'b0};
      left_q <= left_q - CNT_W'(1);
    end
  end

  // R2: never shift past the word length
  a_r2_no_overshift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |-> !last_o);
endmodule

// File: rtl/synth_link_writer.sv
module synth_link_writer
  import synth_link_pkg::*;
#(
  parameter int unsigned DIN_W  = 24,
  parameter int unsigned HALF_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DIN_W-1:0]  data_i,
  input  logic [HALF_W-1:0] half_i,
  output logic              link_en_no,
  output logic              link_clk_o,
  output logic              link_dat_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  link_state_e       state_q;
  logic              over_range;
  logic [DATA_W-1:0] data_fit;
  logic              accept;
  logic              tick;
  logic              shift;
  logic              msb;
  logic              last;

  generate
    if (DIN_W > DATA_W) begin : g_wide
      assign over_range = |data_i[DIN_W-1:DATA_W];
      assign data_fit   = data_i[DATA_W-1:0];
    end else if (DIN_W == DATA_W) begin : g_exact
      assign over_range = 1'b0;
      assign data_fit   = data_i;
    end else begin : g_narrow
      assign over_range = 1'b0;
      assign data_fit   = {{(DATA_W - DIN_W){1'b0}}, data_i};
    end
  endgenerate

  assign accept = (state_q == ST_IDLE) && start_i && !over_range;
  assign shift  = tick && ((state_q == ST_OPEN) || ((state_q == ST_BIT_HI) && !last));
  assign busy_o = (state_q != ST_IDLE);

  link_phase_timer #(.HALF_W(HALF_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .half_i (half_i),
    .run_i  (busy_o),
    .tick_o (tick)
  );

  link_word_shifter #(.FRAME_W(FRAME_W)) u_shifter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .word_i  (pack_word(addr_i, data_fit)),
    .shift_i (shift),
    .msb_o   (msb),
    .last_o  (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      link_en_no <= 1'b1;
      link_clk_o <= 1'b1;
      link_dat_o <= 1'b0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          if (over_range) err_o <= 1'b1;
          else begin
            state_q    <= ST_OPEN;
            link_en_no <= 1'b0;
          end
        end
        ST_OPEN: if (tick) begin
          state_q    <= ST_BIT_LO;
          link_clk_o <= 1'b0;
          link_dat_o <= msb;
        end
        ST_BIT_LO: if (tick) begin
          state_q    <= ST_BIT_HI;
          link_clk_o <= 1'b1;
        end
        ST_BIT_HI: if (tick) begin
          link_clk_o <= 1'b0;
          if (last) begin
            state_q    <= ST_REL_CLK;
            link_dat_o <= 1'b0;
          end else begin
            state_q    <= ST_BIT_LO;
            link_dat_o <= msb;
          end
        end
        ST_REL_CLK: if (tick) begin
          state_q    <= ST_REL_EN;
          link_en_no <= 1'b1;
        end
        ST_REL_EN: if (tick) begin
          state_q    <= ST_IDLE;
          link_clk_o <= 1'b1;
          done_o     <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R1: idle link levels
  a_r1_idle_levels: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (link_en_no && link_clk_o));
  // R4: clock low only inside a transfer
  a_r4_clk_low_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_clk_o |-> busy_o);
  // R5: data held across a rising serial edge
  a_r5_dat_stable_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(link_clk_o) && !link_en_no) |-> $stable(link_dat_o));
  // R6: enable released only while clock low
  a_r6_en_rise_clk_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(link_en_no) |-> !link_clk_o);
  // R8: refusal leaves link idle
  a_r8_err_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!busy_o && link_en_no));
  // R9: no re-entry to the opening phase mid-transfer
  a_r9_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> (state_q != ST_OPEN || $past(state_q) == ST_OPEN));
  // R10: done is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: tb/synth_link_writer_bench.sv
module synth_link_writer_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [23:0] data_i = '0;
  logic [7:0]  half_i = 8'd2;
  logic        link_en_no, link_clk_o, link_dat_o, busy_o, done_o, err_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  synth_link_writer u_synth_link_writer (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .addr_i(addr_i),
    .data_i(data_i), .half_i(half_i), .link_en_no(link_en_no),
    .link_clk_o(link_clk_o), .link_dat_o(link_dat_o), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o)
  );

  // link monitor
  int exp_h = 2;
  int rises = 0, frame_rises = 0, run_len = 0, bad_run = 0;
  int v4 = 0, v5 = 0, v6 = 0, v10 = 0, en_falls = 0, dones = 0, errs = 0;
  logic [21:0] frame_sh = '0;
  logic p_clk = 1'b1, p_en = 1'b1, p_dat = 1'b0, p_done = 1'b0;

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (link_clk_o != p_clk) begin
        if (link_clk_o && !link_en_no) begin
          rises++; frame_rises++;
          frame_sh = {frame_sh[20:0], link_dat_o};
          if (run_len != exp_h) bad_run++;
          if (link_dat_o != p_dat) v5++;
        end
        if (!link_clk_o) begin
          if (link_en_no) v4++;
          else if (frame_rises > 0 && run_len != exp_h) bad_run++;
        end
        run_len = 1;
      end else run_len++;
      if (!link_en_no && p_en) begin
        en_falls++; frame_rises = 0;
        if (!link_clk_o) v4++;
      end
      if (link_en_no && !p_en && (link_clk_o || p_clk || frame_rises != 22)) v6++;
      if (!link_en_no && !p_en && link_clk_o && p_clk && link_dat_o != p_dat) v5++;
      if (done_o && p_done) v10++;
      if (done_o) dones++;
      if (err_o) errs++;
    end
    p_clk = link_clk_o; p_en = link_en_no; p_dat = link_dat_o; p_done = done_o;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    chk(link_en_no == 1'b1, "R1 enable", link_en_no, 1);
    chk(link_clk_o == 1'b1, "R1 clock", link_clk_o, 1);
    chk(link_dat_o == 1'b0, "R1 data", link_dat_o, 0);
    chk({busy_o, done_o, err_o} == 3'b000, "R1 flags", {busy_o, done_o, err_o}, 0);
  endtask

  task automatic t_xfer(input logic [3:0] a, input logic [17:0] d, input logic [7:0] h,
                        input bit intrude);
    int r0, f0, b0, x4, x5, x6, x10, d0, cyc, done_at, hh;
    logic [21:0] exp_word;
    hh = (h < 2) ? 2 : int'(h);
    exp_h = hh;
    exp_word = {d, a};
    r0 = rises; f0 = en_falls; b0 = bad_run; x4 = v4; x5 = v5; x6 = v6; x10 = v10; d0 = dones;
    @(negedge clk_i);
    addr_i = a; data_i = {6'd0, d}; half_i = h; start_i = 1'b1;
    cyc = 0; done_at = -1;
    while (done_at < 0 && cyc < 60 * hh + 10) begin
      @(negedge clk_i);
      cyc++;
      start_i = intrude && (cyc == 10 * hh);
      if (intrude && cyc == 10 * hh) begin
        addr_i = ~a; data_i = {6'd0, ~d}; half_i = h + 8'd3;
      end
      if (cyc == 1) chk(busy_o == 1'b1, "R10 busy after start", busy_o, 1);
      if (done_o) begin
        done_at = cyc;
        chk(busy_o == 1'b0, "R10 busy low at done", busy_o, 0);
        chk(link_clk_o && link_en_no, "R6 idle at done", {link_en_no, link_clk_o}, 3);
      end
    end
    start_i = 1'b0;
    repeat (3 * hh + 5) @(negedge clk_i);
    chk(frame_sh == exp_word, "R2/R3 word bits", frame_sh, exp_word);
    chk(rises - r0 == 22, "R2 rise count", rises - r0, 22);
    chk(bad_run == b0, "R7 phase length", bad_run - b0, 0);
    chk(done_at == 47 * hh + 1, "R7 transfer length", done_at, 47 * hh + 1);
    chk(v4 == x4, "R4 enable/clock order", v4 - x4, 0);
    chk(v5 == x5, "R5 data stability", v5 - x5, 0);
    chk(v6 == x6, "R6 release order", v6 - x6, 0);
    chk(v10 == x10 && dones - d0 == 1, "R10 done pulse", dones - d0, 1);
    chk(en_falls - f0 == 1, "R9 single transfer", en_falls - f0, 1);
    chk(link_en_no && link_clk_o && !busy_o, "R6 idle after", {link_en_no, link_clk_o, busy_o}, 6);
  endtask

  task automatic t_err(input logic [23:0] d);
    int f0, e0;
    f0 = en_falls; e0 = errs;
    @(negedge clk_i);
    data_i = d; addr_i = 4'h3; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(err_o == 1'b1, "R8 err raised", err_o, 1);
    chk(busy_o == 1'b0 && link_en_no, "R8 no start", {busy_o, link_en_no}, 1);
    @(negedge clk_i);
    chk(err_o == 1'b0, "R8 err one cycle", err_o, 0);
    repeat (20) @(negedge clk_i);
    chk(en_falls == f0 && !busy_o, "R8 link untouched", en_falls - f0, 0);
    chk(errs - e0 == 1, "R8 err count", errs - e0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_reset();
    t_xfer(4'h5, 18'h2AAAA, 8'd2, 1'b0);
    t_xfer(4'hF, 18'h3FFFF, 8'd3, 1'b0);
    t_xfer(4'h0, 18'h00001, 8'd1, 1'b0);
    t_xfer(4'h9, 18'h15555, 8'd0, 1'b0);
    t_err(24'h040000);
    t_err(24'hFFFFFF);
    t_xfer(4'hA, 18'h12345, 8'd5, 1'b1);
    t_xfer(4'h6, 18'h0F0F0, 8'd4, 1'b1);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule